// File: doc/BRIEF.md
# Change-Ranked Tile Pixel Updater

The block serves one square tile of a video sensor. It does not read every pixel out on every frame. For each pixel it keeps the value it last sent off the tile. When a new frame streams in, each pixel is compared with that stored value, and the absolute difference becomes the pixel's rank. A pixel whose change is zero, or smaller than a programmable threshold, is dropped at once. Every other pixel is held in a per-tile ranked store.

When the following frame begins, the block drains that store largest change first, up to a programmable per-frame budget. Each drained pixel leaves as an address/value pair, and the tile's memory of what was last sent is updated with that value. Entries that do not fit in the budget are thrown away when the next frame begins. Those pixels are judged again from the fresh frame data, against the unchanged last-sent value.

A frame is opened by a single-cycle `frame_start` pulse. The tile's pixels then follow in raster order on `pix_valid`/`pix_data`. The bench, and the intended system, hold `threshold` steady while a frame streams. They also let the drain of the previous frame finish before the new frame's pixels arrive.

Top module: `spu_tile_updater`

## Requirements
- R1: After reset, `upd_valid` stays low until a frame has been captured and a later `frame_start` begins its drain. Every stored last-sent value reads as zero, so the first frame is ranked against zero.
- R2: Each pixel is ranked by |new value − value last emitted for that address|, not by its change from the previous captured frame.
- R3: A pixel enters the ranked store only if its difference is nonzero and at least `threshold`. A difference of exactly `threshold` is kept, and one of `threshold`−1 is dropped.
- R4: Within one drain, pixels leave in order of decreasing difference. Among equal differences, the lower address leaves first.
- R5: A drain begins at `frame_start` and emits at most `budget` pixels, the value sampled at `frame_start`. A budget of 0 emits nothing. When fewer pixels are stored than the budget allows, every stored pixel is emitted once and the drain stops. Two emissions never fall on adjacent cycles.
- R6: Each emission carries the captured pixel value in `upd_pix`, and that value becomes the pixel's new last-sent value.
- R7: At `frame_start`, entries that are still undrained are discarded. A discarded pixel is emitted later only if the fresh frame data enqueues it again.
- R8: `upd_addr` is the raster index of the pixel (row × side + column). No address is emitted twice within one drain.
- R9: After `frame_start`, the n-th valid pixel gets address n−1. Valid pixels beyond the tile's pixel count are ignored until the next `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse opening a frame; flushes the old queue and starts the drain of the frame just captured |
| pix_valid | input | 1 | A raster pixel is present on `pix_data` |
| pix_data | input | 8 | Pixel sample |
| threshold | input | 8 | Minimum absolute change for a pixel to be queued |
| budget | input | 9 | Maximum number of pixels emitted per drain, sampled at `frame_start` |
| upd_valid | output | 1 | Registered strobe for one emitted pixel |
| upd_addr | output | 8 | Raster address of the emitted pixel |
| upd_pix | output | 8 | Value of the emitted pixel |

## Verification
The bench goes after the following corner cases, and each one catches a particular fault:
- Ties in rank: several pixels are given identical differences. A selector that let a later or equal entry replace the current best would put the higher address out first.
- Threshold boundary: differences of exactly the threshold and one below it are set up. A strict comparison, or a test against the wrong side, would move the emission count by one.
- Comparison reference: a pixel drifts in steps that stay under the threshold relative to the previous frame but pass it relative to the last emitted value. A design that compared against the previous frame would never emit it.
- Flush and budget: a zero budget is used, a budget smaller than the queue is used and the same frame is replayed, and a budget larger than the queue is used. Extra pixels are sent past the end of the tile. A design that kept stale entries, overran the budget or wrapped the raster counter would emit an unexpected address or value.

// File: rtl/spu_pkg.sv
package spu_pkg;
  localparam int unsigned TILE_SIDE_DEF = 16;
  localparam int unsigned PIX_W_DEF     = 8;

  typedef enum logic [1:0] {
    DR_IDLE,
    DR_SCAN,
    DR_EMIT
  } drain_state_t;
endpackage

// File: rtl/spu_sdp_ram.sv
module spu_sdp_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spu_last_store.sv
// Last-sent pixel memory: a RAM with no reset, covered by a per-address
// "written" bit so unwritten locations read as zero after reset.
module spu_last_store #(
  parameter int unsigned AW    = 8,
  parameter int unsigned PIX_W = 8,
  localparam int unsigned NPIX = 1 << AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata
);
  logic [NPIX-1:0]  known;
  logic             known_q;
  logic [PIX_W-1:0] ram_q;

  spu_sdp_ram #(.AW(AW), .DW(PIX_W)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      known   <= '0;
      known_q <= 1'b0;
    end else begin
      if (we) known[waddr] <= 1'b1;
      known_q <= known[raddr];
    end
  end

  assign rdata = known_q ? ram_q : '0;
endmodule

// File: rtl/spu_pending.sv
// Two banks of per-pixel occupancy flags: one bank fills during capture
// while the other is drained.
module spu_pending #(
  parameter int unsigned NPIX = 256,
  localparam int unsigned AW  = $clog2(NPIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          flush_bank,
  input  logic          set_en,
  input  logic          set_bank,
  input  logic [AW-1:0] set_addr,
  input  logic          clr_en,
  input  logic          clr_bank,
  input  logic [AW-1:0] clr_addr,
  input  logic          qry_bank,
  input  logic [AW-1:0] qry_addr,
  output logic          qry_hit
);
  logic [NPIX-1:0] flag [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) flag[b] <= '0;
    end else begin
      if (flush)  flag[flush_bank]           <= '0;
      if (set_en) flag[set_bank][set_addr]   <= 1'b1;
      if (clr_en) flag[clr_bank][clr_addr]   <= 1'b0;
    end
  end

  assign qry_hit = flag[qry_bank][qry_addr];
endmodule

// File: rtl/spu_capture.sv
// Raster address generation, last-sent lookup, absolute difference and
// threshold gate. One pipeline stage between pixel arrival and enqueue.
module spu_capture #(
  parameter int unsigned NPIX  = 256,
  parameter int unsigned PIX_W = 8,
  localparam int unsigned AW   = $clog2(NPIX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sof,
  input  logic               pix_valid,
  input  logic [PIX_W-1:0]   pix_in,
  input  logic [PIX_W-1:0]   thr,
  output logic               cap_bank,
  output logic [AW-1:0]      last_raddr,
  input  logic [PIX_W-1:0]   last_rdata,
  output logic               q_we,
  output logic [AW:0]        q_waddr,
  output logic [2*PIX_W-1:0] q_wdata,
  output logic               set_en,
  output logic               set_bank,
  output logic [AW-1:0]      set_addr
);
  localparam logic [AW:0] NPIX_L = (AW+1)'(NPIX);

  logic [AW:0]      cnt;
  logic             bank_q;
  logic [AW-1:0]    addr_now;
  logic             accept;
  logic             pix_bank;
  logic             s_vld;
  logic [AW-1:0]    s_addr;
  logic [PIX_W-1:0] s_pix;
  logic             s_bank;
  logic [PIX_W-1:0] delta;
  logic             keep;

  assign addr_now   = sof ? '0 : cnt[AW-1:0];
  assign accept     = pix_valid && (sof || (cnt < NPIX_L));
  assign pix_bank   = sof ? ~bank_q : bank_q;
  assign last_raddr = addr_now;
  assign cap_bank   = bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      bank_q <= 1'b0;
      s_vld  <= 1'b0;
      s_addr <= '0;
      s_pix  <= '0;
      s_bank <= 1'b0;
    end else begin
      if (sof) begin
        bank_q <= ~bank_q;
        cnt    <= (AW+1)'(pix_valid);
      end else if (accept) begin
        cnt <= cnt + 1'b1;
      end
      s_vld  <= accept;
      s_addr <= addr_now;
      s_pix  <= pix_in;
      s_bank <= pix_bank;
    end
  end

  always_comb begin
    if (s_pix >= last_rdata) delta = s_pix - last_rdata;
    else                     delta = last_rdata - s_pix;
  end

  assign keep     = s_vld && (delta != '0) && (delta >= thr);
  assign q_we     = keep;
  assign q_waddr  = {s_bank, s_addr};
  assign q_wdata  = {delta, s_pix};
  assign set_en   = keep;
  assign set_bank = s_bank;
  assign set_addr = s_addr;
endmodule

// File: rtl/spu_drain.sv
// Budgeted drain: one linear pass over the tile per emission, keeping the
// strictly largest difference so ties resolve to the lowest address.
module spu_drain
  import spu_pkg::*;
#(
  parameter int unsigned NPIX  = 256,
  parameter int unsigned PIX_W = 8,
  localparam int unsigned AW   = $clog2(NPIX),
  localparam int unsigned BUD_W = AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sof,
  input  logic [BUD_W-1:0]   budget,
  input  logic               drain_bank,
  output logic [AW:0]        q_raddr,
  input  logic [2*PIX_W-1:0] q_rdata,
  output logic [AW-1:0]      qry_addr,
  input  logic               qry_hit,
  output logic               clr_en,
  output logic [AW-1:0]      clr_addr,
  output logic               last_we,
  output logic [AW-1:0]      last_waddr,
  output logic [PIX_W-1:0]   last_wdata,
  output logic               upd_valid,
  output logic [AW-1:0]      upd_addr,
  output logic [PIX_W-1:0]   upd_pix
);
  localparam logic [AW:0]   NPIX_L = (AW+1)'(NPIX);
  localparam logic [AW-1:0] LAST_A = AW'(NPIX - 1);

  drain_state_t     state;
  logic [BUD_W-1:0] left;
  logic [AW:0]      rd_idx;
  logic             st_vld;
  logic [AW-1:0]    st_idx;
  logic             best_found;
  logic [PIX_W-1:0] best_prio;
  logic [AW-1:0]    best_addr;
  logic [PIX_W-1:0] best_val;
  logic             issue;
  logic [PIX_W-1:0] cur_prio;
  logic [PIX_W-1:0] cur_val;
  logic             win;
  logic             pass_end;

  assign issue    = (state == DR_SCAN) && (rd_idx < NPIX_L);
  assign q_raddr  = {drain_bank, rd_idx[AW-1:0]};
  assign qry_addr = st_idx;
  assign cur_prio = q_rdata[2*PIX_W-1:PIX_W];
  assign cur_val  = q_rdata[PIX_W-1:0];
  assign win      = st_vld && qry_hit && (cur_prio > best_prio);
  assign pass_end = st_vld && (st_idx == LAST_A);

  assign clr_en     = (state == DR_EMIT);
  assign clr_addr   = best_addr;
  assign last_we    = (state == DR_EMIT);
  assign last_waddr = best_addr;
  assign last_wdata = best_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= DR_IDLE;
      left       <= '0;
      rd_idx     <= '0;
      st_vld     <= 1'b0;
      st_idx     <= '0;
      best_found <= 1'b0;
      best_prio  <= '0;
      best_addr  <= '0;
      best_val   <= '0;
      upd_valid  <= 1'b0;
      upd_addr   <= '0;
      upd_pix    <= '0;
    end else begin
      upd_valid <= 1'b0;
      if (sof) begin
        state      <= (budget != '0) ? DR_SCAN : DR_IDLE;
        left       <= budget;
        rd_idx     <= '0;
        st_vld     <= 1'b0;
        best_found <= 1'b0;
        best_prio  <= '0;
      end else begin
        case (state)
          DR_SCAN: begin
            st_vld <= issue;
            st_idx <= rd_idx[AW-1:0];
            if (issue) rd_idx <= rd_idx + 1'b1;
            if (win) begin
              best_found <= 1'b1;
              best_prio  <= cur_prio;
              best_addr  <= st_idx;
              best_val   <= cur_val;
            end
            if (pass_end) state <= (best_found || win) ? DR_EMIT : DR_IDLE;
          end
          DR_EMIT: begin
            upd_valid  <= 1'b1;
            upd_addr   <= best_addr;
            upd_pix    <= best_val;
            left       <= left - 1'b1;
            rd_idx     <= '0;
            st_vld     <= 1'b0;
            best_found <= 1'b0;
            best_prio  <= '0;
            state      <= (left == BUD_W'(1)) ? DR_IDLE : DR_SCAN;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spu_tile_updater.sv
module spu_tile_updater
  import spu_pkg::*;
#(
  parameter int unsigned TILE_SIDE = TILE_SIDE_DEF,
  parameter int unsigned PIX_W     = PIX_W_DEF,
  localparam int unsigned NPIX     = TILE_SIDE * TILE_SIDE,
  localparam int unsigned AW       = $clog2(NPIX),
  localparam int unsigned BUD_W    = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [PIX_W-1:0] threshold,
  input  logic [BUD_W-1:0] budget,
  output logic             upd_valid,
  output logic [AW-1:0]    upd_addr,
  output logic [PIX_W-1:0] upd_pix
);
  logic               cap_bank;
  logic [AW-1:0]      last_raddr;
  logic [PIX_W-1:0]   last_rdata;
  logic               q_we;
  logic [AW:0]        q_waddr;
  logic [2*PIX_W-1:0] q_wdata;
  logic [AW:0]        q_raddr;
  logic [2*PIX_W-1:0] q_rdata;
  logic               set_en;
  logic               set_bank;
  logic [AW-1:0]      set_addr;
  logic [AW-1:0]      qry_addr;
  logic               qry_hit;
  logic               clr_en;
  logic [AW-1:0]      clr_addr;
  logic               last_we;
  logic [AW-1:0]      last_waddr;
  logic [PIX_W-1:0]   last_wdata;

  spu_capture #(.NPIX(NPIX), .PIX_W(PIX_W)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .sof        (frame_start),
    .pix_valid  (pix_valid),
    .pix_in     (pix_data),
    .thr        (threshold),
    .cap_bank   (cap_bank),
    .last_raddr (last_raddr),
    .last_rdata (last_rdata),
    .q_we       (q_we),
    .q_waddr    (q_waddr),
    .q_wdata    (q_wdata),
    .set_en     (set_en),
    .set_bank   (set_bank),
    .set_addr   (set_addr)
  );

  spu_last_store #(.AW(AW), .PIX_W(PIX_W)) u_last (
    .clk   (clk),
    .rst   (rst),
    .raddr (last_raddr),
    .rdata (last_rdata),
    .we    (last_we),
    .waddr (last_waddr),
    .wdata (last_wdata)
  );

  // entry store: {bank, address} -> {difference, value}
  spu_sdp_ram #(.AW(AW + 1), .DW(2 * PIX_W)) u_entries (
    .clk   (clk),
    .we    (q_we),
    .waddr (q_waddr),
    .wdata (q_wdata),
    .raddr (q_raddr),
    .rdata (q_rdata)
  );

  spu_pending #(.NPIX(NPIX)) u_pending (
    .clk        (clk),
    .rst        (rst),
    .flush      (frame_start),
    .flush_bank (~cap_bank),
    .set_en     (set_en),
    .set_bank   (set_bank),
    .set_addr   (set_addr),
    .clr_en     (clr_en),
    .clr_bank   (~cap_bank),
    .clr_addr   (clr_addr),
    .qry_bank   (~cap_bank),
    .qry_addr   (qry_addr),
    .qry_hit    (qry_hit)
  );

  spu_drain #(.NPIX(NPIX), .PIX_W(PIX_W)) u_drain (
    .clk        (clk),
    .rst        (rst),
    .sof        (frame_start),
    .budget     (budget),
    .drain_bank (~cap_bank),
    .q_raddr    (q_raddr),
    .q_rdata    (q_rdata),
    .qry_addr   (qry_addr),
    .qry_hit    (qry_hit),
    .clr_en     (clr_en),
    .clr_addr   (clr_addr),
    .last_we    (last_we),
    .last_waddr (last_waddr),
    .last_wdata (last_wdata),
    .upd_valid  (upd_valid),
    .upd_addr   (upd_addr),
    .upd_pix    (upd_pix)
  );
endmodule

// File: rtl/spu_tile_updater_chk.sv
module spu_tile_updater_chk #(
  parameter int unsigned NPIX  = 256,
  parameter int unsigned AW    = 8,
  parameter int unsigned BUD_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic [BUD_W-1:0] budget,
  input logic             upd_valid,
  input logic [AW-1:0]    upd_addr
);
  logic             rst_q;
  logic             started;
  logic [BUD_W-1:0] bud_q;
  logic [BUD_W-1:0] em_cnt;
  logic [NPIX-1:0]  seen;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      started <= 1'b0;
      bud_q   <= '0;
      em_cnt  <= '0;
      seen    <= '0;
    end else if (frame_start) begin
      started <= 1'b1;
      bud_q   <= budget;
      em_cnt  <= '0;
      seen    <= '0;
    end else if (upd_valid) begin
      em_cnt         <= em_cnt + 1'b1;
      seen[upd_addr] <= 1'b1;
    end
  end

  // R1: the cycle after reset is released carries no emission
  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      assert_quiet_after_reset_R1: assert (!upd_valid)
        else $error("emission directly after reset");
    end
  end

  // R1: nothing is emitted before the first frame_start
  assert_no_emit_before_frame_R1: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> started)
    else $error("emission before any frame_start");

  // R5: emissions per drain stay within the sampled budget
  assert_within_budget_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !frame_start) |-> (em_cnt < bud_q))
    else $error("budget exceeded");

  // R5: emissions never fall on adjacent cycles
  assert_spaced_emits_R5: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> !upd_valid)
    else $error("back-to-back emissions");

  // R8: no address repeats inside one drain
  assert_unique_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !frame_start) |-> !seen[upd_addr])
    else $error("address emitted twice in one drain");
endmodule

bind spu_tile_updater spu_tile_updater_chk #(
  .NPIX  (NPIX),
  .AW    (AW),
  .BUD_W (BUD_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .budget      (budget),
  .upd_valid   (upd_valid),
  .upd_addr    (upd_addr)
);

// File: tb/tb_spu_tile_updater.sv
module tb_spu_tile_updater;
  localparam int NPIX = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = '0;
  logic [7:0] threshold = '0;
  logic [8:0] budget = '0;
  logic       upd_valid;
  logic [7:0] upd_addr;
  logic [7:0] upd_pix;

  always #4 clk = ~clk;

  spu_tile_updater dut (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .threshold   (threshold),
    .budget      (budget),
    .upd_valid   (upd_valid),
    .upd_addr    (upd_addr),
    .upd_pix     (upd_pix)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_last [NPIX];
  bit q_on   [NPIX];
  int q_prio [NPIX];
  int q_val  [NPIX];
  int fb     [NPIX];
  int act_addr [NPIX + 8];
  int act_pix  [NPIX + 8];
  int act_n = 0;
  int exp_addr [NPIX];
  int exp_pix  [NPIX];
  int exp_n = 0;

  always @(negedge clk) begin
    if (upd_valid) begin
      if (act_n < NPIX + 8) begin
        act_addr[act_n] = int'(upd_addr);
        act_pix[act_n]  = int'(upd_pix);
      end
      act_n++;
    end
  end

  function automatic int absd(int a, int b);
    return (a >= b) ? a - b : b - a;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // R9: stream the tile in raster order, plus optional surplus pixels
  task automatic stream(int thr, int extra);
    threshold = 8'(thr);
    for (int a = 0; a < NPIX; a++) begin
      int d;
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data  = 8'(fb[a]);
      d = absd(fb[a], m_last[a]);
      if (d != 0 && d >= thr) begin
        q_on[a]   = 1'b1;
        q_prio[a] = d;
        q_val[a]  = fb[a];
      end
    end
    for (int e = 0; e < extra; e++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data  = 8'(fb[e] ^ 128);
    end
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  // R4 R5 R6 R7: open a frame, drain the captured set, compare to model
  task automatic start_frame(int bud, string tag);
    exp_n = 0;
    for (int k = 0; k < bud; k++) begin
      int best;
      best = -1;
      for (int a = 0; a < NPIX; a++)
        if (q_on[a] && (best < 0 || q_prio[a] > q_prio[best])) best = a;
      if (best < 0) break;
      exp_addr[exp_n] = best;
      exp_pix[exp_n]  = q_val[best];
      exp_n++;
      m_last[best] = q_val[best];
      q_on[best] = 1'b0;
    end
    for (int a = 0; a < NPIX; a++) q_on[a] = 1'b0;  // R7 flush of leftovers
    @(negedge clk);
    budget = 9'(bud);
    frame_start = 1'b1;
    act_n = 0;
    @(negedge clk);
    frame_start = 1'b0;
    repeat ((exp_n + 1) * (NPIX + 4) + 10) @(negedge clk);
    chk(act_n == exp_n, $sformatf("R5 emission count [%s]", tag), act_n, exp_n);
    for (int k = 0; k < exp_n && k < act_n; k++) begin
      chk(act_addr[k] == exp_addr[k], $sformatf("R4 R8 address #%0d [%s]", k, tag),
          act_addr[k], exp_addr[k]);
      chk(act_pix[k] == exp_pix[k], $sformatf("R6 value #%0d [%s]", k, tag),
          act_pix[k], exp_pix[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit quiet;
    void'($urandom(32'd20240611));
    for (int a = 0; a < NPIX; a++) begin
      m_last[a] = 0;
      q_on[a] = 1'b0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: quiet after reset
    quiet = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (upd_valid) quiet = 1'b0;
    end
    chk(quiet, "R1 no emission after reset", int'(!quiet), 0);

    // R1 R3 R4: first frame ranked against zero, with directed ties
    for (int a = 0; a < NPIX; a++) fb[a] = int'($urandom_range(0, 255));
    fb[3] = 255; fb[10] = 255; fb[200] = 255; fb[5] = 40; fb[6] = 39;
    stream(40, 0);
    start_frame(6, "R1 first frame vs zero");

    // R7 R9: same data again; leftovers re-enqueued, surplus ignored
    stream(40, 3);
    start_frame(5, "R7 R9 flush and re-evaluate");

    // R5: zero budget
    for (int a = 0; a < NPIX; a++) fb[a] = int'($urandom_range(0, 255));
    stream(0, 0);
    start_frame(0, "R5 zero budget");

    // R4: random ranking
    for (int a = 0; a < NPIX; a++) fb[a] = int'($urandom_range(0, 255));
    stream(30, 0);
    start_frame(8, "R4 random");

    // R3: exact-threshold boundary
    for (int a = 0; a < NPIX; a++) fb[a] = m_last[a];
    fb[20] = (m_last[20] < 128) ? m_last[20] + 16 : m_last[20] - 16;
    fb[21] = (m_last[21] < 128) ? m_last[21] + 15 : m_last[21] - 15;
    stream(16, 0);
    chk(q_on[20] && !q_on[21], "R3 model boundary set", int'(q_on[21]), 0);
    start_frame(10, "R3 threshold boundary");

    // R2: drift judged against last emitted value
    for (int a = 0; a < NPIX; a++) fb[a] = m_last[a];
    fb[50] = 100;
    stream(1, 0);
    start_frame(40, "R2 set reference");
    fb[50] = 110;
    stream(20, 0);
    start_frame(40, "R2 sub-threshold step");
    fb[50] = 125;
    fb[7] = m_last[7] ^ 64;
    fb[9] = m_last[9] ^ 64;
    stream(20, 0);
    start_frame(2, "R2 R4 tie and cumulative change");
    stream(20, 0);
    start_frame(10, "R2 R5 R7 budget above queue");

    // R4 R5: mixed random frames
    for (int f = 0; f < 4; f++) begin
      for (int a = 0; a < NPIX; a++)
        if ($urandom_range(0, 3) == 0) fb[a] = int'($urandom_range(0, 255));
      stream(int'($urandom_range(0, 63)), 0);
      start_frame(int'($urandom_range(1, 12)), "R4 R5 random frame");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule